// File: doc/BRIEF.md
# Dual-Width Sequential Unsigned Divider

This unit divides an unsigned dividend by an unsigned divisor for the execute stage of a small CPU. It produces one quotient bit per clock and works at one of two sizes, chosen for each operation. In byte mode a 16-bit dividend is divided by an 8-bit divisor, giving an 8-bit quotient and an 8-bit remainder. In word mode a 32-bit dividend, formed from a high word and a low word, is divided by a 16-bit divisor, giving a 16-bit quotient and a 16-bit remainder.

An operation starts when `start_i` is sampled high while the unit is idle. The unit then holds `busy_o` high until the cycle in which `done_o` pulses. Before any iteration it compares the upper half of the dividend with the divisor. A divisor of zero, or a quotient that would not fit the selected width, raises the overflow flag. In that case the iterations are skipped and the quotient and remainder carry no meaning. For byte results the unit also presents a packed 16-bit value in the form the register file takes: the quotient in the low byte and the remainder in the high byte.

Top module: `udiv_dual`

## Requirements
- R1: In byte mode (`word_mode_i`=0) with no overflow, `quotient_o[7:0]` equals `dividend_i[15:0]` divided by `divisor_i[7:0]` and `remainder_o[7:0]` is the matching remainder. Bits 15:8 of both outputs are zero.
- R2: In word mode (`word_mode_i`=1) with no overflow, `quotient_o` equals `dividend_i[31:0]` divided by `divisor_i[15:0]` and `remainder_o` is the matching remainder.
- R3: A divisor of zero in the selected width sets `ovf_o` in the done cycle.
- R4: `ovf_o` is set in the done cycle when the true quotient needs more than 8 bits (byte mode) or more than 16 bits (word mode).
- R5: `ovf_o` is cleared in the done cycle of every operation that has neither overflow condition.
- R6: In byte mode `divisor_i[15:8]` and `dividend_i[31:16]` have no effect on any output.
- R7: Counting the edge that accepts `start_i` as edge 1, `done_o` is high after edge 9 in byte mode and after edge 17 in word mode. When overflow is detected it is high after edge 1. It stays high for exactly one cycle.
- R8: `busy_o` is high from the accepting edge through the done cycle. A `start_i` pulse while `busy_o` is high is ignored, and the running operation's results are unaffected.
- R9: After the done cycle, `quotient_o`, `remainder_o`, `ovf_o` and `byte_pack_o` hold their values until the next start is accepted.
- R10: `byte_pack_o` equals `{remainder_o[7:0], quotient_o[7:0]}`: the remainder in the high byte and the quotient in the low byte.
- R11: After synchronous reset (`rst_n`=0 at a clock edge), `busy_o`, `done_o`, `ovf_o`, `quotient_o` and `remainder_o` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| start_i | input | 1 | Request a division; taken only while idle |
| word_mode_i | input | 1 | 1 selects word size, 0 selects byte size |
| dividend_i | input | 32 | Dividend; byte mode uses bits 15:0 |
| divisor_i | input | 16 | Divisor; byte mode uses bits 7:0 |
| busy_o | output | 1 | Operation in progress, including the done cycle |
| done_o | output | 1 | One-cycle completion pulse |
| quotient_o | output | 16 | Quotient, zero-extended in byte mode |
| remainder_o | output | 16 | Remainder, zero-extended in byte mode |
| ovf_o | output | 1 | Divide-by-zero or quotient too wide |
| byte_pack_o | output | 16 | Byte-mode result: remainder high byte, quotient low byte |

## Verification
The assertions assume that `start_i`, `word_mode_i` and the operands are at known levels once reset has been released. They also assume that the iteration starts with a partial remainder below the divisor, which holds only because overflowing operations never iterate. The bench applies every stimulus at the falling edge and keeps every input defined at all times, including the stray start pulses it applies mid-operation. It uses quotient and remainder values only when its own model predicts no overflow.

// File: rtl/udiv_pkg.sv
// Package: shared state encoding and width helpers for the dual-width divider.
// Assumes: the narrow width is strictly smaller than the wide width.
package udiv_pkg;

    // Controller phases: waiting, iterating, completion pulse.
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_DONE = 2'd2
    } udiv_state_e;

    // Default operand widths of the wide and narrow sizes.
    localparam int unsigned WIDE_W_DEF   = 16;
    localparam int unsigned NARROW_W_DEF = 8;

endpackage

// File: rtl/udiv_prep.sv
// Module: udiv_prep
// Narrows and aligns the operands for the selected size and flags overflow
// before any iteration. The partial remainder starts as the upper half of the
// dividend. The quotient shift register starts with the lower half,
// left-aligned so that its MSB is always the next bit to bring down.
// Assumes NARROW_W < WIDE_W. Purely combinational.
module udiv_prep #(
    parameter int unsigned WIDE_W   = 16,
    parameter int unsigned NARROW_W = 8
) (
    input  logic                  word_mode,
    input  logic [2*WIDE_W-1:0]   dividend,
    input  logic [WIDE_W-1:0]     divisor,
    output logic [WIDE_W-1:0]     rem_init,
    output logic [WIDE_W-1:0]     quo_init,
    output logic [WIDE_W-1:0]     dvs_eff,
    output logic                  ovf
);
    localparam int unsigned PAD_W = WIDE_W - NARROW_W;

    logic [WIDE_W-1:0] rem_narrow;
    logic [WIDE_W-1:0] quo_narrow;
    logic [WIDE_W-1:0] dvs_narrow;

    // Byte-size alignment: zero-extend the upper half and the divisor, left-align the lower half.
    always_comb begin
        rem_narrow = {{PAD_W{1'b0}}, dividend[2*NARROW_W-1:NARROW_W]};
        quo_narrow = {dividend[NARROW_W-1:0], {PAD_W{1'b0}}};
        dvs_narrow = {{PAD_W{1'b0}}, divisor[NARROW_W-1:0]};
    end

    // Size select and early overflow test (the test also catches a zero divisor).
    always_comb begin
        if (word_mode) begin
            rem_init = dividend[2*WIDE_W-1:WIDE_W];
            quo_init = dividend[WIDE_W-1:0];
            dvs_eff  = divisor;
        end else begin
            rem_init = rem_narrow;
            quo_init = quo_narrow;
            dvs_eff  = dvs_narrow;
        end
        ovf = (rem_init >= dvs_eff);
    end

    // R3: a zero effective divisor must always be reported as overflow
    always_comb begin
        if (dvs_eff == '0) begin
            zero_div_ovf_chk: assert (ovf)
                else $error("zero divisor not flagged");
        end
    end

endmodule

// File: rtl/udiv_step.sv
// Module: udiv_step
// One restoring shift-subtract iteration. The MSB of the quotient register is
// shifted into the partial remainder, a trial subtraction is made, and the
// result bit is shifted into the quotient LSB.
// Assumes the incoming partial remainder is below the divisor. Combinational.
module udiv_step #(
    parameter int unsigned WIDE_W = 16
) (
    input  logic [WIDE_W-1:0] rem_in,
    input  logic [WIDE_W-1:0] quo_in,
    input  logic [WIDE_W-1:0] dvs,
    output logic [WIDE_W-1:0] rem_out,
    output logic [WIDE_W-1:0] quo_out
);
    logic [WIDE_W:0] trial;
    logic [WIDE_W:0] diff;
    logic            fits;

    // Trial subtraction on one extra bit so the shifted remainder never wraps.
    always_comb begin
        trial = {rem_in, quo_in[WIDE_W-1]};
        diff  = trial - {1'b0, dvs};
        fits  = (trial >= {1'b0, dvs});
    end

    // Restore or keep the difference, and shift the new quotient bit in.
    always_comb begin
        rem_out = fits ? diff[WIDE_W-1:0] : trial[WIDE_W-1:0];
        quo_out = {quo_in[WIDE_W-2:0], fits};
    end

    // R2: the remainder invariant survives each step
    always_comb begin
        if ((rem_in < dvs) && !$isunknown({rem_in, quo_in, dvs})) begin
            step_rem_bound_chk: assert (rem_out < dvs)
                else $error("partial remainder escaped divisor bound");
        end
    end

endmodule

// File: rtl/udiv_ctrl.sv
// Module: udiv_ctrl
// Sequencing for the divider: takes a start only when idle, runs 8 or 16
// iteration cycles, and pulses done for one cycle. An operation with
// overflow goes straight to the done cycle.
// Assumes a synchronous active-low reset.
module udiv_ctrl #(
    parameter int unsigned WIDE_W   = 16,
    parameter int unsigned NARROW_W = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic word_mode,
    input  logic ovf_now,
    output logic load,
    output logic iterate,
    output logic busy,
    output logic done
);
    import udiv_pkg::*;

    localparam int unsigned CNT_W = $clog2(WIDE_W);
    localparam logic [CNT_W-1:0] LAST_WIDE   = CNT_W'(WIDE_W - 1);
    localparam logic [CNT_W-1:0] LAST_NARROW = CNT_W'(NARROW_W - 1);

    udiv_state_e      state_q, state_d;
    logic [CNT_W-1:0] cnt_q,   cnt_d;

    // Strobes for the datapath.
    always_comb begin
        load    = (state_q == ST_IDLE) && start;
        iterate = (state_q == ST_RUN);
        busy    = (state_q != ST_IDLE);
        done    = (state_q == ST_DONE);
    end

    // Next state and iteration counter.
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            ST_IDLE: if (start) begin
                state_d = ovf_now ? ST_DONE : ST_RUN;
                cnt_d   = word_mode ? LAST_WIDE : LAST_NARROW;
            end
            ST_RUN: begin
                if (cnt_q == '0) state_d = ST_DONE;
                else             cnt_d   = cnt_q - 1'b1;
            end
            ST_DONE: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // State and counter registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // R7: the done pulse lasts one cycle
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R7: leaving the run phase happens only on an exhausted counter
    run_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (iterate && cnt_q != '0) |=> iterate);

    // R8: a start during busy does not re-enter loading
    busy_no_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !load);

endmodule

// File: rtl/udiv_dual.sv
// Module: udiv_dual (top)
// Dual-width unsigned divider. It holds the partial remainder, the quotient
// shift register, the latched divisor and the size, and drives them from
// udiv_prep on a load and from udiv_step on each iteration. Results stay
// valid from the done cycle until the next load.
// Assumes inputs are defined at each accepting edge. Synchronous active-low reset.
module udiv_dual #(
    parameter int unsigned WIDE_W   = udiv_pkg::WIDE_W_DEF,
    parameter int unsigned NARROW_W = udiv_pkg::NARROW_W_DEF
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  start_i,
    input  logic                  word_mode_i,
    input  logic [2*WIDE_W-1:0]   dividend_i,
    input  logic [WIDE_W-1:0]     divisor_i,
    output logic                  busy_o,
    output logic                  done_o,
    output logic [WIDE_W-1:0]     quotient_o,
    output logic [WIDE_W-1:0]     remainder_o,
    output logic                  ovf_o,
    output logic [2*NARROW_W-1:0] byte_pack_o
);
    localparam int unsigned PAD_W = WIDE_W - NARROW_W;

    logic [WIDE_W-1:0] rem_init, quo_init, dvs_eff;
    logic              ovf_now;
    logic [WIDE_W-1:0] rem_step, quo_step;
    logic              load, iterate;

    logic [WIDE_W-1:0] rem_q, quo_q, dvs_q;
    logic              ovf_q, mode_q;

    udiv_prep #(.WIDE_W(WIDE_W), .NARROW_W(NARROW_W)) u_prep (
        .word_mode (word_mode_i),
        .dividend  (dividend_i),
        .divisor   (divisor_i),
        .rem_init  (rem_init),
        .quo_init  (quo_init),
        .dvs_eff   (dvs_eff),
        .ovf       (ovf_now)
    );

    udiv_step #(.WIDE_W(WIDE_W)) u_step (
        .rem_in  (rem_q),
        .quo_in  (quo_q),
        .dvs     (dvs_q),
        .rem_out (rem_step),
        .quo_out (quo_step)
    );

    udiv_ctrl #(.WIDE_W(WIDE_W), .NARROW_W(NARROW_W)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start_i),
        .word_mode (word_mode_i),
        .ovf_now   (ovf_now),
        .load      (load),
        .iterate   (iterate),
        .busy      (busy_o),
        .done      (done_o)
    );

    // Operand and result registers: load on accept, advance on each iteration.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rem_q  <= '0;
            quo_q  <= '0;
            dvs_q  <= '0;
            ovf_q  <= 1'b0;
            mode_q <= 1'b0;
        end else if (load) begin
            rem_q  <= rem_init;
            quo_q  <= quo_init;
            dvs_q  <= dvs_eff;
            ovf_q  <= ovf_now;
            mode_q <= word_mode_i;
        end else if (iterate) begin
            rem_q  <= rem_step;
            quo_q  <= quo_step;
        end
    end

    // Result presentation: mask the quotient to the narrow width in byte mode, and pack.
    always_comb begin
        quotient_o  = mode_q ? quo_q : {{PAD_W{1'b0}}, quo_q[NARROW_W-1:0]};
        remainder_o = rem_q;
        ovf_o       = ovf_q;
        byte_pack_o = {remainder_o[NARROW_W-1:0], quotient_o[NARROW_W-1:0]};
    end

    // R1: a good byte-size result has a remainder that fits the narrow width
    byte_rem_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !ovf_o && !mode_q) |-> (remainder_o[WIDE_W-1:NARROW_W] == '0));

    // R2: a good result has a remainder below the divisor
    rem_below_dvs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !ovf_o) |-> (remainder_o < dvs_q));

    // R3: a zero divisor ends flagged
    zero_dvs_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && dvs_q == '0) |-> ovf_o);

    // R6: byte mode latches no divisor bits above the narrow width
    byte_dvs_narrow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (load && !word_mode_i) |=> (dvs_q[WIDE_W-1:NARROW_W] == '0));

    // R8: operands stay put while an operation is under way
    busy_operands_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !done_o) |=> ($stable(dvs_q) && $stable(mode_q) && $stable(ovf_q)));

    // R9: results hold while idle
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && !load) |=> ($stable(quotient_o) && $stable(remainder_o) && $stable(ovf_o)));

endmodule

// File: tb/udiv_dual_tb.sv
// Self-checking bench for udiv_dual. A behavioural model built on integer
// arithmetic predicts busy, done and the results on every clock.
module udiv_dual_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic        word_mode_i = 1'b0;
    logic [31:0] dividend_i = '0;
    logic [15:0] divisor_i = '0;
    logic        busy_o, done_o, ovf_o;
    logic [15:0] quotient_o, remainder_o, byte_pack_o;

    int errors = 0;
    int checks = 0;

    always #4 clk = ~clk;   // 125 MHz

    udiv_dual u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start_i),
        .word_mode_i (word_mode_i),
        .dividend_i  (dividend_i),
        .divisor_i   (divisor_i),
        .busy_o      (busy_o),
        .done_o      (done_o),
        .quotient_o  (quotient_o),
        .remainder_o (remainder_o),
        .ovf_o       (ovf_o),
        .byte_pack_o (byte_pack_o)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
        end
    endtask

    // Run one division, comparing busy and done on every cycle against the model.
    // poke: apply a stray start with different operands during the run (R8).
    task automatic run_op(input bit wm, input logic [31:0] dvd, input logic [15:0] dvs,
                          input bit poke);
        longint unsigned n_dvd, n_dvs, exp_q, exp_r;
        bit   exp_ovf;
        int   lat;
        logic [15:0] hq, hr;
        logic        hv;
        n_dvd = wm ? longint'(dvd) : longint'(dvd[15:0]);
        n_dvs = wm ? longint'(dvs) : longint'(dvs[7:0]);
        exp_ovf = (n_dvs == 0) || ((n_dvd >> (wm ? 16 : 8)) >= n_dvs);
        exp_q = exp_ovf ? 0 : n_dvd / n_dvs;
        exp_r = exp_ovf ? 0 : n_dvd % n_dvs;
        lat   = exp_ovf ? 1 : (wm ? 17 : 9);

        @(negedge clk);
        word_mode_i = wm;
        dividend_i  = dvd;
        divisor_i   = dvs;
        start_i     = 1'b1;
        for (int e = 1; e <= lat; e++) begin
            @(posedge clk);
            @(negedge clk);
            start_i = 1'b0;
            // R8: busy through the done cycle
            chk(busy_o == 1'b1, "R8", "busy", busy_o, 1);
            // R7: done exactly at the predicted edge
            chk(done_o == (e == lat), "R7", "done timing", done_o, (e == lat));
            if (e == lat) begin
                if (exp_ovf) begin
                    chk(ovf_o == 1'b1, (n_dvs == 0) ? "R3" : "R4", "ovf set", ovf_o, 1);
                end else begin
                    chk(ovf_o == 1'b0, "R5", "ovf clear", ovf_o, 0);
                    chk(quotient_o == exp_q[15:0], wm ? "R2" : "R1", "quotient",
                        quotient_o, exp_q);
                    chk(remainder_o == exp_r[15:0], wm ? "R2" : "R1", "remainder",
                        remainder_o, exp_r);
                    if (!wm)
                        chk(byte_pack_o == {exp_r[7:0], exp_q[7:0]}, "R10", "pack",
                            byte_pack_o, {exp_r[7:0], exp_q[7:0]});
                end
            end else if (poke && e == 2) begin
                word_mode_i = ~wm;
                dividend_i  = 32'h0000_0101;
                divisor_i   = 16'h0003;
                start_i     = 1'b1;
            end
        end
        hq = quotient_o; hr = remainder_o; hv = ovf_o;
        repeat (2) begin
            @(posedge clk);
            @(negedge clk);
            chk(busy_o == 1'b0 && done_o == 1'b0, "R7", "idle after done",
                {busy_o, done_o}, 0);
            chk(quotient_o == hq && remainder_o == hr && ovf_o == hv, "R9", "hold",
                {quotient_o, remainder_o}, {hq, hr});
        end
    endtask

    // Watchdog: a hung run is a failed check.
    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL R7 watchdog expired: actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R11: reset state
        chk(busy_o == 0 && done_o == 0 && ovf_o == 0, "R11", "reset flags",
            {busy_o, done_o, ovf_o}, 0);
        chk(quotient_o == 0 && remainder_o == 0, "R11", "reset results",
            {quotient_o, remainder_o}, 0);
        rst_n = 1'b1;

        // R1: plain byte divisions
        run_op(1'b0, 32'h0000_03E8, 16'h0007, 1'b0);
        run_op(1'b0, 32'h0000_0005, 16'h0009, 1'b0);
        // R1: quotient exactly 0xFF
        run_op(1'b0, 32'h0000_FEFF, 16'h00FF, 1'b0);
        // R2: plain word divisions
        run_op(1'b1, 32'h1234_5678, 16'h9ABC, 1'b0);
        // R2: quotient exactly 0xFFFF
        run_op(1'b1, 32'hFFFE_FFFF, 16'hFFFF, 1'b0);
        // R3: zero divisor in both sizes
        run_op(1'b0, 32'h0000_1234, 16'h0000, 1'b0);
        run_op(1'b1, 32'h0000_1234, 16'h0000, 1'b0);
        // R3 with R6: upper divisor bits set but narrow part zero
        run_op(1'b0, 32'h0000_0010, 16'h5500, 1'b0);
        // R4: maximum dividends overflow
        run_op(1'b0, 32'h0000_FFFF, 16'h00FF, 1'b0);
        run_op(1'b1, 32'hFFFF_FFFF, 16'hFFFF, 1'b0);
        // R4: quotient one past the narrow limit
        run_op(1'b0, 32'h0000_0100, 16'h0001, 1'b0);
        // R5: a good operation right after an overflow clears the flag
        run_op(1'b1, 32'h0000_0064, 16'h000A, 1'b0);
        // R6: ignored upper divisor and dividend bits in byte mode
        run_op(1'b0, 32'hABCD_0100, 16'h1203, 1'b0);
        // R8: stray start during busy, both sizes
        run_op(1'b0, 32'h0000_7531, 16'h00C9, 1'b1);
        run_op(1'b1, 32'h7FFF_0001, 16'hF00D, 1'b1);

        // Random operands in both sizes, biased so most do not overflow.
        for (int i = 0; i < 200; i++) begin
            logic [31:0] d;
            logic [15:0] v;
            d = $urandom;
            v = 16'($urandom);
            if (i % 4 != 0) d[31:16] = d[31:16] % (v | 16'h0001);
            run_op(1'b1, d, v, (i % 17) == 0);
        end
        for (int i = 0; i < 200; i++) begin
            logic [31:0] d;
            logic [15:0] v;
            d = $urandom;
            v = 16'($urandom);
            if (i % 4 != 0) d[15:8] = d[15:8] % (v[7:0] | 8'h01);
            run_op(1'b0, d, v, (i % 13) == 0);
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule